// File: doc/BRIEF.md
# Change-Detect Timestamped Input Logger

This block watches a wide digital input bus and keeps a record only when something of interest changes. The input bus is sampled on each cycle in which a scan enable is high. Each sample is compared with the previous one. If any line that is both selected by a per-line trigger mask and not set up as an output has changed, the block stores one record in an on-chip FIFO. A record holds a timestamp and the full input word. The timestamp counts scan ticks since capture was started.

The scan enable sets the sampling rate, so it also sets the shortest pulse that can be seen. At the fastest rate it is high every other clock. The lines form groups of equal width, and a per-group direction bit removes a whole group from change detection. A level run control starts and stops capture. When run rises, the timestamp goes back to zero, the overflow flag is cleared and the next scan is always stored. That gives a known starting state. Records that are already queued stay through a restart.

Software-side logic drains the FIFO through a show-ahead read port. The head record is presented whenever the FIFO is not empty. If a capture arrives while the FIFO is full, it is dropped and a sticky overflow flag is raised. Stored records are never overwritten.

Top module: `chg_log_top`

## Requirements
- R1: After reset, empty is 1, full is 0 and overflow is 0.
- R2: The first scan tick while run is high after run was low always stores a record, whatever the mask. Its timestamp is 0 and its state is the sampled input word.
- R3: A scan whose sampled word equals the previous sample on every masked input line stores nothing.
- R4: A scan in which at least one masked input line differs from the previous sample stores one record. The record holds the current timestamp and all DATA_W sampled lines, including unmasked ones.
- R5: A change on a line whose trigger mask bit (bit i gates line i) is 0 stores nothing.
- R6: Line i belongs to group i/GROUP_W. When that group's direction bit is 1 (output), changes on line i store nothing, even if its mask bit is 1.
- R7: The timestamp is 0 at the first scan after start and rises by one per scan tick taken while run is high. Clocks without scan enable do not advance it. It wraps modulo 2^TS_W.
- R8: No record is stored while scan enable is low or run is low, even if inputs change.
- R9: After DEPTH records are held without reads, full is 1. Further captures are dropped and overflow becomes 1 and stays 1. The DEPTH stored records read back unchanged.
- R10: Overflow returns to 0 when run rises.
- R11: Records read out in the order they were stored. The head appears on rd_ts/rd_state while empty is 0, and rd_en pops it. A read while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Capture enable level; rising edge restarts the timestamp |
| scan_en | input | 1 | Scan tick qualifier |
| din | input | 64 | Monitored input lines |
| trig_mask | input | 64 | Per-line trigger enable |
| grp_out | input | 4 | Per-group output direction; 1 removes the group from detection |
| rd_en | input | 1 | Pop the head record |
| rd_ts | output | 32 | Timestamp of the head record |
| rd_state | output | 64 | Input word of the head record |
| empty | output | 1 | No record held |
| full | output | 1 | DEPTH records held |
| overflow | output | 1 | Sticky: a capture was dropped because the FIFO was full |

## Verification
A corrupted previous-sample register shows up at the ports within one scan tick. It appears as a record that should not exist, or as a missing one, visible through empty on the next clock. A wrong timestamp counter is seen in the next record read out, because the bench predicts every timestamp from the count of scan ticks it has issued. Pointer or count faults in the FIFO show up as a wrong full or empty flag at the 512th write, or as records returned out of order during the full drain.

// File: rtl/chg_log_pkg.sv
package chg_log_pkg;
   localparam int DEF_DATA_W  = 64;
   localparam int DEF_GROUP_W = 16;
   localparam int DEF_TS_W    = 32;
   localparam int DEF_DEPTH   = 512;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/chg_log_detect.sv
module chg_log_detect
   import chg_log_pkg::*;
#(
   parameter int DATA_W  = DEF_DATA_W,
   parameter int GROUP_W = DEF_GROUP_W,
   parameter int TS_W    = DEF_TS_W,
   localparam int N_GRP  = DATA_W / GROUP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              scan_en,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] trig_mask,
   input  logic [N_GRP-1:0]  grp_out,
   output logic              wr_req,
   output logic [TS_W-1:0]   wr_ts,
   output logic [DATA_W-1:0] wr_state
);
   if (DATA_W % GROUP_W != 0) begin : g_bad_group
      $error("DATA_W must be a multiple of GROUP_W");
   end
   if (TS_W < 2) begin : g_bad_ts
      $error("TS_W too small");
   end

   logic [DATA_W-1:0] dir_mask;
   logic [DATA_W-1:0] prev_q;
   logic [TS_W-1:0]   ts_q;
   logic              first_q;
   logic              active;
   logic              hit;

   for (genvar g = 0; g < N_GRP; g++) begin : g_dir
      assign dir_mask[g*GROUP_W +: GROUP_W] = {GROUP_W{grp_out[g]}};
   end

   always_comb begin
      active   = run & scan_en;
      hit      = |((din ^ prev_q) & trig_mask & ~dir_mask);
      wr_req   = active & (first_q | hit);
      wr_ts    = ts_q;
      wr_state = din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ts_q    <= '0;
         first_q <= 1'b1;
         prev_q  <= '0;
      end else if (!run) begin
         ts_q    <= '0;
         first_q <= 1'b1;
      end else if (scan_en) begin
         ts_q    <= ts_q + 1'b1;
         first_q <= 1'b0;
         prev_q  <= din;
      end
   end

   // R7: timestamp frozen between scan ticks
   p_ts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !scan_en) |=> $stable(ts_q));
   // R7: timestamp parked at zero while stopped
   p_ts_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (ts_q == '0));
   // R2: a scan after a stopped cycle is always captured
   p_first_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run ##1 (run && scan_en)) |-> wr_req);
endmodule

// File: rtl/chg_log_fifo.sv
module chg_log_fifo
   import chg_log_pkg::*;
#(
   parameter int WIDTH = DEF_DATA_W + DEF_TS_W,
   parameter int DEPTH = DEF_DEPTH,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_ovf,
   input  logic             wr_req,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full,
   output logic             overflow
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;
   logic             do_wr, do_rd;

   if (is_pow2(DEPTH)) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_comb begin
      empty   = (count == '0);
      full    = (count == CW'(DEPTH));
      do_wr   = wr_req & ~full;
      do_rd   = rd_en & ~empty;
      rd_data = mem[rd_ptr];
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         overflow <= (overflow & ~clr_ovf) | (wr_req & full);
      end
   end

   // R9: a write into a full FIFO never moves the write pointer
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && full) |=> $stable(wr_ptr));
   // R9: overflow is sticky until cleared
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !clr_ovf) |=> overflow);
   // R11: reading while empty keeps the read pointer still
   p_rd_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en) |=> $stable(rd_ptr));
   // R1: flags never both asserted
   p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));
endmodule

// File: rtl/chg_log_top.sv
module chg_log_top
   import chg_log_pkg::*;
#(
   parameter int DATA_W  = DEF_DATA_W,
   parameter int GROUP_W = DEF_GROUP_W,
   parameter int TS_W    = DEF_TS_W,
   parameter int DEPTH   = DEF_DEPTH,
   localparam int N_GRP  = DATA_W / GROUP_W,
   localparam int REC_W  = TS_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              scan_en,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] trig_mask,
   input  logic [N_GRP-1:0]  grp_out,
   input  logic              rd_en,
   output logic [TS_W-1:0]   rd_ts,
   output logic [DATA_W-1:0] rd_state,
   output logic              empty,
   output logic              full,
   output logic              overflow
);
   logic              run_q;
   logic              start;
   logic              wr_req;
   logic [TS_W-1:0]   wr_ts;
   logic [DATA_W-1:0] wr_state;
   logic [REC_W-1:0]  rd_rec;

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run;
   end
   assign start = run & ~run_q;

   chg_log_detect #(
      .DATA_W (DATA_W),
      .GROUP_W(GROUP_W),
      .TS_W   (TS_W)
   ) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .scan_en  (scan_en),
      .din      (din),
      .trig_mask(trig_mask),
      .grp_out  (grp_out),
      .wr_req   (wr_req),
      .wr_ts    (wr_ts),
      .wr_state (wr_state)
   );

   chg_log_fifo #(
      .WIDTH(REC_W),
      .DEPTH(DEPTH)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_ovf (start),
      .wr_req  (wr_req),
      .wr_data ({wr_ts, wr_state}),
      .rd_en   (rd_en),
      .rd_data (rd_rec),
      .empty   (empty),
      .full    (full),
      .overflow(overflow)
   );

   assign rd_ts    = rd_rec[REC_W-1 -: TS_W];
   assign rd_state = rd_rec[DATA_W-1:0];

   // R10: overflow cleared on the cycle after a start
   p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !full) |=> !overflow);
   // R8: nothing is stored while stopped
   p_idle_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !rd_en && empty) |=> empty);
endmodule

// File: tb/chg_log_top_bench.sv
module chg_log_top_bench;
   localparam int DEPTH = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        scan_en = 1'b0;
   logic [63:0] din = '0;
   logic [63:0] trig_mask = '0;
   logic [3:0]  grp_out = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_ts;
   logic [63:0] rd_state;
   logic        empty, full, overflow;

   int checks = 0;
   int errors = 0;

   logic [95:0] q[$];
   logic [63:0] m_prev = '0;
   logic [31:0] m_ts = '0;
   bit          m_first = 1'b1;

   always #10 clk = ~clk;

   chg_log_top u_chg_log_top (
      .clk(clk), .rst_n(rst_n), .run(run), .scan_en(scan_en), .din(din),
      .trig_mask(trig_mask), .grp_out(grp_out), .rd_en(rd_en),
      .rd_ts(rd_ts), .rd_state(rd_state), .empty(empty), .full(full),
      .overflow(overflow)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] dir_mask();
      logic [63:0] m;
      for (int g = 0; g < 4; g++) m[g*16 +: 16] = {16{grp_out[g]}};
      return m;
   endfunction

   task automatic set_run(input logic v);
      run = v;
      if (!v) begin m_ts = '0; m_first = 1'b1; end
      @(negedge clk);
   endtask

   task automatic do_scan(input logic [63:0] d);
      bit cap;
      din = d;
      scan_en = 1'b1;
      cap = m_first || (|((d ^ m_prev) & trig_mask & ~dir_mask()));
      if (cap && q.size() < DEPTH) q.push_back({m_ts, d});
      m_prev = d; m_ts++; m_first = 1'b0;
      @(negedge clk);
      scan_en = 1'b0;
   endtask

   task automatic pop_expect(input string tag);
      logic [95:0] e;
      e = q.pop_front();
      check(!empty && {rd_ts, rd_state} == e, tag, {rd_ts, rd_state}, e);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic expect_empty(input string tag);
      check(empty == 1'b1, tag, 96'(empty), 96'd1);
   endtask

   task automatic t_reset;
      check(empty && !full && !overflow, "R1 reset flags",
            96'({empty, full, overflow}), 96'b100);
   endtask

   task automatic t_first;
      trig_mask = '0;
      set_run(1'b1);
      do_scan(64'hDEAD_BEEF_0123_4567);
      pop_expect("R2 first scan stored ts=0");
      expect_empty("R2 single record");
      do_scan(64'h1111_0000_0000_0001);
      expect_empty("R5 unmasked change ignored");
   endtask

   task automatic t_masked;
      trig_mask = 64'h20;
      do_scan(64'h1111_0100_0000_0021);
      pop_expect("R4 masked change record with full state");
      do_scan(64'h1111_0100_0000_0021);
      expect_empty("R3 unchanged scan stores nothing");
   endtask

   task automatic t_idle;
      din = 64'h0;
      repeat (5) @(negedge clk);
      expect_empty("R8 no scan enable no record");
      do_scan(64'h0);
      pop_expect("R7 timestamp counts scan ticks only");
   endtask

   task automatic t_dir;
      trig_mask = 64'h0010_0000;
      grp_out = 4'b0010;
      do_scan(64'h0010_0000);
      expect_empty("R6 output group excluded");
      grp_out = 4'b0000;
      do_scan(64'h0);
      pop_expect("R6 group back to input detects");
   endtask

   task automatic t_overflow;
      set_run(1'b0);
      din = 64'hFFFF;
      @(negedge clk);
      expect_empty("R8 run low no record");
      set_run(1'b1);
      trig_mask = '1;
      for (int i = 0; i < DEPTH + 3; i++) do_scan(i[0] ? 64'hA5 : 64'h5A);
      check(full, "R9 full after DEPTH", 96'(full), 96'd1);
      check(overflow, "R9 overflow set", 96'(overflow), 96'd1);
      repeat (3) @(negedge clk);
      check(overflow, "R9 overflow sticky", 96'(overflow), 96'd1);
      while (q.size() > 0) pop_expect("R9 R11 stored records intact in order");
      expect_empty("R11 drained");
      check(overflow, "R9 overflow holds after drain", 96'(overflow), 96'd1);
   endtask

   task automatic t_restart;
      trig_mask = '0;
      set_run(1'b0);
      set_run(1'b1);
      check(!overflow, "R10 overflow cleared on start", 96'(overflow), 96'd0);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      expect_empty("R11 read on empty ignored");
      do_scan(64'h77);
      pop_expect("R2 restart first record ts=0");
      expect_empty("R11 empty after pop");
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first();
      t_masked();
      t_idle();
      t_dir();
      t_overflow();
      t_restart();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule